// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Control Lock

The block is a watchdog down-counter behind a small register port. When software fails to restart it in time, the first expiry raises a one-cycle system-management interrupt pulse. The counter then reloads and runs a second time. If that second period also expires, a sticky second-timeout flag is set and, unless rebooting is inhibited, a one-cycle reboot request is issued.

A 16-bit control word holds a halt bit that freezes counting, a lock bit that, once set, stays set until reset and blocks changes to the separate timer-enable register, two legacy bits that store and return data without any effect, and a no-reboot bit. On each rising edge of power-good the no-reboot bit is loaded from a strap input. A high strap pins it to 1. A low strap leaves it under full software control.

The sequencer has three named states. In FIRST the block counts toward the interrupt. On expiry of FIRST (the counter is at zero when a tick arrives) it moves to SECOND. On expiry of SECOND it moves to DONE. DONE holds until a restart. A restart command moves any state back to FIRST. The counter advances only when the timer is enabled and not halted. From a loaded value N, expiry takes N+1 such cycles.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, the enable register (address 1) reads 0, the reload register (address 2) reads its reset value of 15, the status register (address 3) reads 0, and all outputs are low.
- R2: Control word layout: bit 12 is lock, bit 11 is halt, bits 9 and 8 are legacy bits, and bit 0 is no-reboot. Bits 15:13, 10 and 7:1 always read 0, whatever is written to them.
- R3: Writing 1 to bit 12 sets the lock. Writing 0 does not clear it. Only reset clears it.
- R4: While the lock is 1, writes to the enable register (bit 0 of address 1) leave its value unchanged.
- R5: While halt is 1, the counter does not advance, and no interrupt pulse, no status set and no reboot request occur.
- R6: In FIRST, the tick that finds the counter at zero produces a one-cycle pulse on `smi_pulse`, reloads the counter from the reload register and enters SECOND.
- R7: In SECOND, the tick that finds the counter at zero sets `second_to_sts`, enters DONE and, only if no-reboot is 0, produces a one-cycle `reboot_req` pulse.
- R8: On a rising edge of `pwr_good` the no-reboot bit takes the value of `strap_nr`. While the captured strap is 1, software writes cannot clear no-reboot. While it is 0, software writes set or clear it freely.
- R9: Legacy bits 9 and 8 read back what was written and have no effect on counting or outputs.
- R10: The second-timeout status reads at bit 1 of address 3. Writing 1 to that bit clears it. A same-cycle expiry wins over the clear.
- R11: Writing 1 to bit 0 of address 3 loads the counter from the reload register and returns to FIRST from any state, cancelling a pending second phase. The restart wins over a same-cycle expiry.
- R12: With enable at 0, the counter does not advance and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| pwr_good | input | 1 | Power-good level; its rising edge captures the strap |
| strap_nr | input | 1 | No-reboot strap level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 enable, 2 reload, 3 status/command) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| smi_pulse | output | 1 | One-cycle interrupt pulse on the first expiry |
| second_to_sts | output | 1 | Sticky second-timeout status |
| reboot_req | output | 1 | One-cycle reboot request on the second expiry |

## Verification
The assertions check on every cycle that the lock never falls, that the enable register stays still while locked, that a halted timer emits nothing, that no reboot request appears while no-reboot is set or without the status flag, that both pulses last a single cycle, that a captured high strap keeps no-reboot at 1, and that reserved control bits read as zero. The expiry timing from a given reload value, the two-phase order, a restart cancelling the second phase, write-1-to-clear, the legacy bits' lack of effect and the lock surviving until reset show up only in the bench's scenarios. There, a behavioural model is compared with the outputs on every clock.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_EN     = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
    localparam logic [ADDR_W-1:0] A_CMD    = 2'd3;

    localparam int B_LOCK     = 12;
    localparam int B_HALT     = 11;
    localparam int B_LEG9     = 9;
    localparam int B_LEG8     = 8;
    localparam int B_NOREBOOT = 0;
    localparam int B_RESTART  = 0;
    localparam int B_STS      = 1;

    localparam logic [DATA_W-1:0] CTRL_RSVD_MASK = 16'hE4FE;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_DONE   = 2'd2
    } phase_e;
endpackage

// File: rtl/wd_strap_latch.sv
module wd_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic strap_nr,
    output logic pg_rise,
    output logic strap_q
);
    logic pg_q;

    assign pg_rise = pwr_good & ~pg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q    <= 1'b0;
            strap_q <= 1'b0;
        end else begin
            pg_q <= pwr_good;
            if (pg_rise) begin
                strap_q <= strap_nr;
            end
        end
    end
endmodule

// File: rtl/wd_ctrl_regs.sv
module wd_ctrl_regs
    import wd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int RELOAD_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              pg_rise,
    input  logic              strap_nr,
    input  logic              strap_q,
    input  logic              sts_set,
    output logic              lock,
    output logic              halt,
    output logic              no_reboot,
    output logic              tmr_en,
    output logic [CNT_W-1:0]  reload_val,
    output logic              restart,
    output logic              sts,
    output logic [DATA_W-1:0] reg_rdata
);
    logic leg9, leg8;
    logic wr_ctrl, wr_en, wr_reload, wr_cmd;

    assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
    assign wr_en     = reg_we && (reg_addr == A_EN);
    assign wr_reload = reg_we && (reg_addr == A_RELOAD);
    assign wr_cmd    = reg_we && (reg_addr == A_CMD);
    assign restart   = wr_cmd && reg_wdata[B_RESTART];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock <= 1'b0;
            halt <= 1'b0;
            leg9 <= 1'b0;
            leg8 <= 1'b0;
        end else if (wr_ctrl) begin
            lock <= lock | reg_wdata[B_LOCK];
            halt <= reg_wdata[B_HALT];
            leg9 <= reg_wdata[B_LEG9];
            leg8 <= reg_wdata[B_LEG8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            no_reboot <= 1'b0;
        end else if (pg_rise) begin
            no_reboot <= strap_nr;
        end else if (wr_ctrl) begin
            no_reboot <= strap_q | reg_wdata[B_NOREBOOT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_en <= 1'b0;
        end else if (wr_en && !lock) begin
            tmr_en <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_val <= CNT_W'(RELOAD_RST);
        end else if (wr_reload) begin
            reload_val <= reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (sts_set) begin
            sts <= 1'b1;
        end else if (wr_cmd && reg_wdata[B_STS]) begin
            sts <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_LOCK]     = lock;
                reg_rdata[B_HALT]     = halt;
                reg_rdata[B_LEG9]     = leg9;
                reg_rdata[B_LEG8]     = leg8;
                reg_rdata[B_NOREBOOT] = no_reboot;
            end
            A_EN:     reg_rdata[0] = tmr_en;
            A_RELOAD: reg_rdata[CNT_W-1:0] = reload_val;
            A_CMD:    reg_rdata[B_STS] = sts;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wd_phase_fsm.sv
module wd_phase_fsm
    import wd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int RELOAD_RST = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             halt,
    input  logic             no_reboot,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload_val,
    output logic             sts_set,
    output logic             smi_pulse,
    output logic             reboot_req
);
    phase_e           state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             tick, at_zero, expire1, expire2;

    assign tick    = tmr_en && !halt;
    assign at_zero = (cnt == '0);
    assign expire1 = !restart && tick && at_zero && (state == PH_FIRST);
    assign expire2 = !restart && tick && at_zero && (state == PH_SECOND);
    assign sts_set = expire2;

    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = PH_FIRST;
        end else if (tick && at_zero) begin
            unique case (state)
                PH_FIRST:  state_nx = PH_SECOND;
                PH_SECOND: state_nx = PH_DONE;
                PH_DONE:   state_nx = PH_DONE;
                default:   state_nx = PH_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_FIRST;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RELOAD_RST);
        end else if (restart || expire1) begin
            cnt <= reload_val;
        end else if (tick && !at_zero && (state != PH_DONE)) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_pulse  <= 1'b0;
            reboot_req <= 1'b0;
        end else begin
            smi_pulse  <= expire1;
            reboot_req <= expire2 && !no_reboot;
        end
    end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int RELOAD_RST = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              strap_nr,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              smi_pulse,
    output logic              second_to_sts,
    output logic              reboot_req
);
    logic             pg_rise, strap_q;
    logic             ctrl_lock, ctrl_halt, ctrl_nr, tmr_en, restart, sts_set;
    logic [CNT_W-1:0] reload_val;

    wd_strap_latch u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .strap_nr (strap_nr),
        .pg_rise  (pg_rise),
        .strap_q  (strap_q)
    );

    wd_ctrl_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pg_rise    (pg_rise),
        .strap_nr   (strap_nr),
        .strap_q    (strap_q),
        .sts_set    (sts_set),
        .lock       (ctrl_lock),
        .halt       (ctrl_halt),
        .no_reboot  (ctrl_nr),
        .tmr_en     (tmr_en),
        .reload_val (reload_val),
        .restart    (restart),
        .sts        (second_to_sts),
        .reg_rdata  (reg_rdata)
    );

    wd_phase_fsm #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_en     (tmr_en),
        .halt       (ctrl_halt),
        .no_reboot  (ctrl_nr),
        .restart    (restart),
        .reload_val (reload_val),
        .sts_set    (sts_set),
        .smi_pulse  (smi_pulse),
        .reboot_req (reboot_req)
    );
endmodule

// File: rtl/wd_chk.sv
module wd_chk
    import wd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic              halt,
    input logic              nr,
    input logic              strap_q,
    input logic              tmr_en,
    input logic              smi_pulse,
    input logic              reboot_req,
    input logic              second_to_sts,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R4
    en_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(tmr_en));

    // R5
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!smi_pulse && !reboot_req && !$rose(second_to_sts)));

    // R7
    no_reboot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nr |=> !reboot_req);

    // R7
    reboot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |-> second_to_sts);

    // R6
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pulse |=> !smi_pulse);

    // R7
    reboot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req);

    // R8
    strap_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q |-> nr);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |-> ((reg_rdata & CTRL_RSVD_MASK) == '0));
endmodule

bind wdt_two_stage wd_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lock          (ctrl_lock),
    .halt          (ctrl_halt),
    .nr            (ctrl_nr),
    .strap_q       (strap_q),
    .tmr_en        (tmr_en),
    .smi_pulse     (smi_pulse),
    .reboot_req    (reboot_req),
    .second_to_sts (second_to_sts),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata)
);

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/1ps
module test_wdt_two_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b1;
    logic        strap_nr = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        smi_pulse, second_to_sts, reboot_req;

    int checks = 0;
    int errors = 0;
    int n_smi = 0;
    int n_rb = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    wdt_two_stage i_wdt_two_stage (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_nr(strap_nr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi_pulse(smi_pulse),
        .second_to_sts(second_to_sts), .reboot_req(reboot_req)
    );

    // behavioural reference model
    int m_lock, m_halt, m_nr, m_strap, m_pgq, m_en, m_rel, m_cnt, m_ph;
    int m_sts, m_smi, m_rb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_halt = 0; m_nr = 0; m_strap = 0; m_pgq = 0;
            m_en = 0; m_rel = 15; m_cnt = 15; m_ph = 1;
            m_sts = 0; m_smi = 0; m_rb = 0;
        end else begin
            int run, go, clr, rise, hit2;
            run  = (m_en != 0) && (m_halt == 0);
            go   = reg_we && reg_addr == 3 && reg_wdata[0];
            clr  = reg_we && reg_addr == 3 && reg_wdata[1];
            rise = pwr_good && (m_pgq == 0);
            hit2 = 0;
            m_smi = 0;
            m_rb = 0;
            if (go) begin
                m_ph = 1; m_cnt = m_rel;
            end else if (run) begin
                if (m_ph == 1) begin
                    if (m_cnt == 0) begin m_smi = 1; m_ph = 2; m_cnt = m_rel; end
                    else m_cnt = m_cnt - 1;
                end else if (m_ph == 2) begin
                    if (m_cnt == 0) begin hit2 = 1; m_rb = (m_nr == 0); m_ph = 3; end
                    else m_cnt = m_cnt - 1;
                end
            end
            if (hit2) m_sts = 1;
            else if (clr) m_sts = 0;
            if (reg_we && reg_addr == 1 && m_lock == 0) m_en = reg_wdata[0];
            if (reg_we && reg_addr == 2) m_rel = reg_wdata[9:0];
            if (rise) m_nr = strap_nr;
            else if (reg_we && reg_addr == 0) m_nr = m_strap | reg_wdata[0];
            if (reg_we && reg_addr == 0) begin
                if (reg_wdata[12]) m_lock = 1;
                m_halt = reg_wdata[11];
            end
            if (rise) m_strap = strap_nr;
            m_pgq = pwr_good;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (smi_pulse) n_smi++;
            if (reboot_req) n_rb++;
            checks++;
            if (smi_pulse !== m_smi[0] || reboot_req !== m_rb[0] || second_to_sts !== m_sts[0]) begin
                errors++;
                $display("FAIL R5 R6 R7 R10 R11 per-cycle: smi/rb/sts actual %b%b%b expected %b%b%b",
                         smi_pulse, reboot_req, second_to_sts, m_smi[0], m_rb[0], m_sts[0]);
            end
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1 rst_n = 1'b0;
        idle(3);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        int s0, r0;
        idle(3);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(0, 16'h0000, "R1 ctrl");
        rd(1, 16'h0000, "R1 enable");
        rd(2, 16'h000F, "R1 reload");
        rd(3, 16'h0000, "R1 status");
        chk(smi_pulse + reboot_req, 0, "R1 outputs");
        // R2 reserved bits read zero
        wr(0, 16'hE4FE);
        rd(0, 16'h0000, "R2 reserved");
        // R9 legacy bits store
        wr(0, 16'h0300);
        rd(0, 16'h0300, "R9 legacy");
        // R8 strap low: software owns no-reboot
        wr(0, 16'h0301);
        rd(0, 16'h0301, "R8 set");
        wr(0, 16'h0300);
        rd(0, 16'h0300, "R8 clear");
        // R12 disabled timer does not count
        wr(2, 16'd3);
        wr(3, 16'h0001);
        idle(20);
        chk(n_smi, 0, "R12 no expiry");
        // R6 R7 both expiries with reboot; R9 legacy set throughout
        wr(1, 16'h0001);
        idle(20);
        chk(n_smi, 1, "R6 smi count");
        chk(n_rb, 1, "R7 reboot count");
        rd(3, 16'h0002, "R7 status");
        // R10 write-1-to-clear
        wr(3, 16'h0002);
        rd(3, 16'h0000, "R10 cleared");
        // R7 no-reboot suppresses request
        wr(0, 16'h0001);
        wr(3, 16'h0001);
        idle(20);
        chk(n_smi, 2, "R7 smi with nr");
        chk(n_rb, 1, "R7 no reboot");
        rd(3, 16'h0002, "R7 status nr");
        wr(3, 16'h0002);
        // R11 restart cancels second phase
        wr(2, 16'd6);
        wr(0, 16'h0000);
        wr(3, 16'h0001);
        for (int i = 0; i < 40 && n_smi < 3; i++) @(negedge clk);
        wr(3, 16'h0001);
        idle(5);
        rd(3, 16'h0000, "R11 no status");
        chk(n_rb, 1, "R11 no reboot");
        idle(20);
        chk(n_smi, 4, "R11 restarted first phase");
        wr(3, 16'h0002);
        // R5 halt freezes
        s0 = n_smi; r0 = n_rb;
        wr(0, 16'h0800);
        wr(3, 16'h0001);
        idle(40);
        chk(n_smi - s0, 0, "R5 halted smi");
        chk(n_rb - r0, 0, "R5 halted reboot");
        rd(3, 16'h0000, "R5 halted status");
        wr(0, 16'h0000);
        idle(20);
        chk(n_smi - s0, 1, "R5 resumed smi");
        chk(n_rb - r0, 1, "R5 resumed reboot");
        // R4 R3 lock
        wr(0, 16'h1000);
        rd(0, 16'h1000, "R3 lock set");
        wr(1, 16'h0000);
        rd(1, 16'h0001, "R4 enable held");
        wr(0, 16'h0000);
        rd(0, 16'h1000, "R3 lock sticky");
        do_reset();
        rd(0, 16'h0000, "R3 reset clears lock");
        rd(1, 16'h0000, "R1 enable after reset");
        // R8 strap high pins no-reboot
        @(negedge clk);
        strap_nr = 1'b1; pwr_good = 1'b0;
        idle(2);
        pwr_good = 1'b1;
        idle(2);
        rd(0, 16'h0001, "R8 strap captured");
        wr(0, 16'h0000);
        rd(0, 16'h0001, "R8 cannot clear");
        r0 = n_rb; s0 = n_smi;
        wr(2, 16'd2);
        wr(1, 16'h0001);
        wr(3, 16'h0001);
        idle(20);
        chk(n_smi - s0, 1, "R8 smi strap");
        chk(n_rb - r0, 0, "R8 no reboot strap");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule